// File: doc/BRIEF.md
# Fixed-Priority Vectored Interrupt Controller

This block arbitrates the interrupt requests of a small 8-bit core. Eleven peripheral sources each present a pending flag and an individual enable bit. A global enable bit, which is the core's status-register bit 7, gates all of them. When the global bit is set, the core is between instructions, and at least one source is both pending and enabled, the block picks the source whose vector address is lowest. It issues a one-cycle take pulse to the core with that source's vector word, and sends a one-cycle acknowledge to the winning source so that the source can drop its flag.

Accepting an interrupt clears the global bit in hardware, so a handler cannot be interrupted unless it says so. A return-from-interrupt strobe sets the global bit again, and the core can also set or clear the bit directly. Sources that stay pending while the bit is clear are not lost. They are evaluated again as soon as the bit returns. Vector word 0 belongs to reset. Source index i (0 to 10) owns vector word i+1, so index 0 (external interrupt 0) outranks every other source.

Top module: `vic_ctrl`

## Requirements
- R1: After reset, `gie` is 0, `irq_take` is 0, `src_ack` is all zeros and `irq_vector` is 0x000, the reset vector.
- R2: An accepted source with index i (bit i of `src_pend`/`src_en`) is presented as `irq_vector` = VEC_BASE + i + 1. With the default base, 0x001 is external interrupt 0 and 0x00B is ADC complete.
- R3: When several enabled sources are pending, the one with the lowest bit index, and therefore the lowest vector address, is accepted.
- R4: A source is accepted only if its `src_en` bit and `gie` are both 1. A pending source that is disabled is never acknowledged.
- R5: Acceptance is decided on a clock edge from the inputs and `gie` sampled there. In the cycle that follows, `irq_take` is 1 for exactly one cycle and `src_ack` is one-hot on the winner.
- R6: The edge that accepts an interrupt also clears `gie`.
- R7: Without an acceptance, `gie_clr_cmd` clears `gie`. Otherwise `gie_set_cmd` or `ret_strobe` sets it, and otherwise it holds. A clear beats a set given on the same cycle.
- R8: While `core_busy` is 1, nothing is accepted, so `src_ack` stays zero and `irq_vector` stays unchanged.
- R9: Sources left pending while `gie` is 0 are accepted on the first edge at which `gie` is 1 and `core_busy` is 0, still in priority order.
- R10: `irq_vector` changes only on an acceptance and holds its value between acceptances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_pend | input | NUM_SRC | Pending flag of each source, bit i = source i |
| src_en | input | NUM_SRC | Individual enable of each source |
| gie_set_cmd | input | 1 | Core command: set the global enable |
| gie_clr_cmd | input | 1 | Core command: clear the global enable |
| ret_strobe | input | 1 | Return-from-interrupt executed: set the global enable |
| core_busy | input | 1 | Core is mid-instruction; hold off acceptance |
| irq_take | output | 1 | One-cycle pulse: jump to `irq_vector` |
| irq_vector | output | ADDR_W | Program word of the accepted vector |
| src_ack | output | NUM_SRC | One-cycle one-hot acknowledge to the winner |
| gie | output | 1 | Global interrupt enable (status bit 7) |

## Verification
The assertions assume that a source keeps its pending flag until it is acknowledged, and that it clears the flag within a cycle of the acknowledge. They also assume that all inputs are driven and free of X from the cycle after reset. The bench models each source as a peripheral that raises flags at random and drops a flag only on the negative edge after its acknowledge. The core commands, busy and enables are drawn at random but never left undriven. The directed cases add simultaneous set/clear, busy over a pending request, and a chain of returns that drains a full set of pending sources in order.

// File: rtl/vic_pkg.sv
// Package: shared names for the vectored interrupt controller.
// Assumes the default source order; the index of a source is its priority rank.
package vic_pkg;

    // Source ranks: lower value means higher priority and lower vector word.
    typedef enum logic [3:0] {
        SRC_EXT0      = 4'd0,
        SRC_PINCHG    = 4'd1,
        SRC_T1_CMPA   = 4'd2,
        SRC_T1_CMPB   = 4'd3,
        SRC_T1_OVF    = 4'd4,
        SRC_T0_OVF    = 4'd5,
        SRC_SER_START = 4'd6,
        SRC_SER_OVF   = 4'd7,
        SRC_NVM_READY = 4'd8,
        SRC_ACOMP     = 4'd9,
        SRC_ADC_DONE  = 4'd10
    } vic_src_e;

    localparam int unsigned VIC_RESET_WORD = 0;

endpackage

// File: rtl/vic_prio_pick.sv
// Module: lowest-index-wins priority picker.
// Assumes NUM_SRC >= 2. Purely combinational: gives the index and the one-hot
// mask of the lowest set bit of req, plus a flag saying whether any bit is set.
module vic_prio_pick #(
    parameter int unsigned NUM_SRC = 11,
    localparam int unsigned IDX_W  = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0] req,
    output logic               any,
    output logic [IDX_W-1:0]   idx,
    output logic [NUM_SRC-1:0] onehot
);

    // Mask of requests below each position, built bit by bit.
    logic [NUM_SRC-1:0] below;

    genvar g;
    generate
        for (g = 0; g < NUM_SRC; g++) begin : g_mask
            if (g == 0) begin : g_first
                assign below[g]  = 1'b0;
            end else begin : g_rest
                assign below[g]  = below[g-1] | req[g-1];
            end
            assign onehot[g] = req[g] & ~below[g];
        end
    endgenerate

    // Any-request flag.
    assign any = |req;

    // Encode the winner's index; scanning downward leaves the lowest set bit.
    always_comb begin
        idx = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/vic_gie_reg.sv
// Module: global interrupt enable bit (status bit 7).
// Assumes accept can only be 1 while the bit is 1. Acceptance clears the bit
// and beats every command; a clear command beats set and return.
module vic_gie_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic accept,
    input  logic set_cmd,
    input  logic clr_cmd,
    input  logic ret_strobe,
    output logic gie
);

    // Update the global enable from acceptance and core commands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gie <= 1'b0;
        end else if (accept) begin
            gie <= 1'b0;
        end else if (clr_cmd) begin
            gie <= 1'b0;
        end else if (set_cmd || ret_strobe) begin
            gie <= 1'b1;
        end
    end

endmodule

// File: rtl/vic_launch.sv
// Module: registers the take pulse, the acknowledge and the vector word.
// Assumes win_onehot is one-hot whenever accept is 1. The vector resets to the
// reset word and only changes on an acceptance.
module vic_launch #(
    parameter int unsigned NUM_SRC  = 11,
    parameter int unsigned ADDR_W   = 12,
    parameter int unsigned VEC_BASE = 0,
    localparam int unsigned IDX_W   = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               accept,
    input  logic [IDX_W-1:0]   win_idx,
    input  logic [NUM_SRC-1:0] win_onehot,
    output logic               take,
    output logic [NUM_SRC-1:0] ack,
    output logic [ADDR_W-1:0]  vector
);

    localparam logic [ADDR_W-1:0] RESET_VEC = ADDR_W'(VEC_BASE + vic_pkg::VIC_RESET_WORD);

    // Vector word of the current winner: base plus one word past reset.
    logic [ADDR_W-1:0] win_vec;
    assign win_vec = ADDR_W'(VEC_BASE) + ADDR_W'(win_idx) + ADDR_W'(1);

    // One-cycle take and acknowledge pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take <= 1'b0;
            ack  <= '0;
        end else begin
            take <= accept;
            ack  <= accept ? win_onehot : '0;
        end
    end

    // Latch the vector word on acceptance only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vector <= RESET_VEC;
        end else if (accept) begin
            vector <= win_vec;
        end
    end

endmodule

// File: rtl/vic_ctrl.sv
// Module: fixed-priority vectored interrupt controller (top).
// Assumes sources hold their pending flag until acknowledged, and that the core
// raises core_busy whenever it cannot branch to a vector on the next cycle.
module vic_ctrl #(
    parameter int unsigned NUM_SRC  = 11,
    parameter int unsigned ADDR_W   = 12,
    parameter int unsigned VEC_BASE = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_pend,
    input  logic [NUM_SRC-1:0] src_en,
    input  logic               gie_set_cmd,
    input  logic               gie_clr_cmd,
    input  logic               ret_strobe,
    input  logic               core_busy,
    output logic               irq_take,
    output logic [ADDR_W-1:0]  irq_vector,
    output logic [NUM_SRC-1:0] src_ack,
    output logic               gie
);

    localparam int unsigned IDX_W = $clog2(NUM_SRC);

    logic [NUM_SRC-1:0] cand;
    logic               cand_any;
    logic [IDX_W-1:0]   cand_idx;
    logic [NUM_SRC-1:0] cand_onehot;
    logic               accept;

    // Eligible sources: pending, individually enabled and globally enabled.
    assign cand   = src_pend & src_en & {NUM_SRC{gie}};

    // Accept only between instructions.
    assign accept = cand_any & ~core_busy;

    vic_prio_pick #(
        .NUM_SRC (NUM_SRC)
    ) pick_i (
        .req    (cand),
        .any    (cand_any),
        .idx    (cand_idx),
        .onehot (cand_onehot)
    );

    vic_gie_reg gie_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .set_cmd    (gie_set_cmd),
        .clr_cmd    (gie_clr_cmd),
        .ret_strobe (ret_strobe),
        .gie        (gie)
    );

    vic_launch #(
        .NUM_SRC  (NUM_SRC),
        .ADDR_W   (ADDR_W),
        .VEC_BASE (VEC_BASE)
    ) launch_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .win_idx    (cand_idx),
        .win_onehot (cand_onehot),
        .take       (irq_take),
        .ack        (src_ack),
        .vector     (irq_vector)
    );

endmodule

// File: rtl/vic_ctrl_chk.sv
// Module: assertion checker for vic_ctrl, attached by bind below.
// Assumes the same parameters as the checked instance.
module vic_ctrl_chk #(
    parameter int unsigned NUM_SRC = 11,
    parameter int unsigned ADDR_W  = 12
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] src_pend,
    input logic [NUM_SRC-1:0] src_en,
    input logic               gie_set_cmd,
    input logic               gie_clr_cmd,
    input logic               ret_strobe,
    input logic               core_busy,
    input logic               irq_take,
    input logic [ADDR_W-1:0]  irq_vector,
    input logic [NUM_SRC-1:0] src_ack,
    input logic               gie
);

    // Bits of sources ranked above the acknowledged one.
    logic [NUM_SRC-1:0] ack_lower;
    assign ack_lower = src_ack - NUM_SRC'(1);

    // R5: acknowledge is one-hot or idle, and present exactly with take.
    a_r5_ack_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(src_ack));
    a_r5_take_has_ack: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |-> ($countones(src_ack) == 1));
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |=> !irq_take);

    // R4: only a pending, enabled source under global enable is acknowledged.
    a_r4_gated: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |-> ($past(gie) && ((src_ack & ~$past(src_pend & src_en)) == '0)));

    // R3: no higher-priority eligible source was passed over.
    a_r3_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |-> ((ack_lower & $past(src_pend & src_en)) == '0));

    // R6: acceptance leaves the global enable cleared.
    a_r6_gie_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |-> !gie);

    // R7: a clear command always wins; set or return wins when nothing is accepted.
    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $past(gie_clr_cmd) |-> !gie);
    a_r7_set: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(gie_set_cmd || ret_strobe) && $past(!gie_clr_cmd) && !irq_take) |-> gie);

    // R8: nothing is accepted over a busy core.
    a_r8_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        $past(core_busy) |-> (!irq_take && $stable(irq_vector)));

    // R10: the vector changes only together with a take pulse.
    a_r10_vec_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_take |-> $stable(irq_vector));

endmodule

bind vic_ctrl vic_ctrl_chk #(
    .NUM_SRC (NUM_SRC),
    .ADDR_W  (ADDR_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .src_pend    (src_pend),
    .src_en      (src_en),
    .gie_set_cmd (gie_set_cmd),
    .gie_clr_cmd (gie_clr_cmd),
    .ret_strobe  (ret_strobe),
    .core_busy   (core_busy),
    .irq_take    (irq_take),
    .irq_vector  (irq_vector),
    .src_ack     (src_ack),
    .gie         (gie)
);

// File: tb/vic_ctrl_tb_top.sv
// Bench: random peripherals and core commands against a cycle model,
// plus directed corner cases with fixed expected values.
module vic_ctrl_tb_top;

    localparam int N       = 11;
    localparam int AW      = 12;
    localparam int CLK_PER = 10;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [N-1:0]  src_pend;
    logic [N-1:0]  src_en;
    logic          gie_set_cmd, gie_clr_cmd, ret_strobe, core_busy;
    logic          irq_take;
    logic [AW-1:0] irq_vector;
    logic [N-1:0]  src_ack;
    logic          gie;

    int n_chk = 0;
    int n_bad = 0;

    // Model state.
    logic          m_gie;
    logic          m_take;
    logic [N-1:0]  m_ack;
    logic [AW-1:0] m_vec;

    always #(CLK_PER/2) clk = ~clk;

    vic_ctrl #(.NUM_SRC(N), .ADDR_W(AW), .VEC_BASE(0)) dut_i (
        .clk(clk), .rst_n(rst_n), .src_pend(src_pend), .src_en(src_en),
        .gie_set_cmd(gie_set_cmd), .gie_clr_cmd(gie_clr_cmd),
        .ret_strobe(ret_strobe), .core_busy(core_busy),
        .irq_take(irq_take), .irq_vector(irq_vector),
        .src_ack(src_ack), .gie(gie)
    );

    function automatic int lowest(input logic [N-1:0] v);
        for (int i = 0; i < N; i++) if (v[i]) return i;
        return -1;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // One cycle: drive at negedge, predict, check a quarter period after the edge.
    task automatic step(input logic set, input logic clr, input logic ret, input logic busy);
        logic [N-1:0] cand;
        logic         acc;
        int           w;
        @(negedge clk);
        gie_set_cmd = set; gie_clr_cmd = clr; ret_strobe = ret; core_busy = busy;
        cand = src_pend & src_en;
        acc  = !busy && m_gie && (cand != '0);
        w    = lowest(cand);
        m_take = acc;
        m_ack  = acc ? (N'(1) << w) : '0;
        if (acc) m_vec = AW'(w + 1);
        m_gie  = acc ? 1'b0 : clr ? 1'b0 : (set || ret) ? 1'b1 : m_gie;
        @(posedge clk);
        #(CLK_PER/4);
        chk("R5 take", int'(irq_take), int'(m_take));
        chk("R3 ack", int'(src_ack), int'(m_ack));
        chk("R2 vector", int'(irq_vector), int'(m_vec));
        chk("R7 gie", int'(gie), int'(m_gie));
        // Peripheral drops its flag once acknowledged.
        src_pend = src_pend & ~src_ack;
    endtask

    initial begin
        #(CLK_PER * 200000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1c0d));
        rst_n = 1'b0; src_pend = '0; src_en = '0;
        gie_set_cmd = 0; gie_clr_cmd = 0; ret_strobe = 0; core_busy = 0;
        m_gie = 0; m_take = 0; m_ack = '0; m_vec = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        // R1: reset state.
        chk("R1 gie", int'(gie), 0);
        chk("R1 take", int'(irq_take), 0);
        chk("R1 ack", int'(src_ack), 0);
        chk("R1 vector", int'(irq_vector), 0);

        // R4: pending but disabled is never taken.
        src_pend = '1; src_en = '0;
        step(1, 0, 0, 0);
        step(0, 0, 0, 0);
        step(0, 0, 0, 0);
        chk("R4 disabled no take", int'(irq_take), 0);

        // R3/R2: sources 3 and 7 enabled and pending; 3 wins with word 0x004.
        src_pend = N'((1 << 3) | (1 << 7)); src_en = '1;
        step(0, 0, 0, 0);
        chk("R2 vector of src3", int'(irq_vector), 4);
        chk("R3 ack of src3", int'(src_ack), 1 << 3);
        chk("R6 gie cleared", int'(gie), 0);
        step(0, 0, 0, 0);
        chk("R5 one-cycle take", int'(irq_take), 0);
        chk("R10 vector held", int'(irq_vector), 4);

        // R9: source 7 stays pending, taken right after the return.
        step(0, 0, 1, 0);
        step(0, 0, 0, 0);
        chk("R9 src7 after return", int'(irq_vector), 8);

        // R8: busy blocks acceptance and holds the vector.
        src_pend = N'(1 << 0);
        step(1, 0, 0, 1);
        step(0, 0, 0, 1);
        chk("R8 busy no take", int'(irq_take), 0);
        chk("R8 busy vector held", int'(irq_vector), 8);
        step(0, 0, 0, 0);
        chk("R2 ext0 word", int'(irq_vector), 1);

        // R7: clear beats set on the same cycle.
        step(1, 1, 1, 0);
        chk("R7 clear wins", int'(gie), 0);

        // R9: full set drained in order, one per return.
        src_pend = '1;
        step(0, 0, 1, 1);
        for (int k = 0; k < N; k++) begin
            step(0, 0, 0, 0);
            chk("R9 drain order", int'(irq_vector), k + 1);
            step(0, 0, 1, 0);
        end
        chk("R9 drained", int'(src_pend), 0);

        // Random phase.
        for (int t = 0; t < 4000; t++) begin
            src_pend = src_pend | N'($urandom & $urandom & $urandom);
            if (($urandom % 16) == 0) src_en = N'($urandom);
            step(($urandom % 16) == 0, ($urandom % 16) == 0,
                 ($urandom % 6) == 0, ($urandom % 4) == 0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule